// File: doc/BRIEF.md
# Interleaved Read/Write Address Sequencer

This block drives the single address bus of a memory that feeds an in-place block-transform engine. Clock cycles alternate between a fetch slot and a store slot. In a fetch slot the bus carries the location of the next input word and a read strobe is raised. In a store slot the bus carries the location where a finished result word goes and a write strobe is raised. Two independent address counters, one for each slot kind, sit behind a two-way selector that is steered by a phase flip-flop.

The store counter begins a fixed number of positions behind the fetch counter. A result that leaves the engine a set number of slot pairs after its input word was fetched is therefore written back over that same input word. The engine needs no address path of its own. With the default parameters the bus is 18 bits wide and covers a 256 KB array. The fetch counter starts at 0x00000 and the store counter starts at 0x3FFF9, so during every store slot the two counters are exactly 8 apart.

The reset input is asynchronous and active-low. Its release is synchronised to the clock inside the block before the sequence starts.

Top module: `ilv_addr_seq`

## Requirements
- R1: While rst_n_i is low, rd_en_o and wr_en_o are both 0. Within three clock cycles after rst_n_i is released, the first cycle with a strobe high is a read cycle with addr_o = RD_BASE (0x00000 by default).
- R2: After reset, cycles strictly alternate, starting with a read cycle. In a read cycle rd_en_o = 1 and wr_en_o = 0. In a write cycle wr_en_o = 1 and rd_en_o = 0. The two strobes are never high together.
- R3: In the n-th read cycle after reset (n counted from 0), addr_o = RD_BASE + n, modulo 2^ADDR_W.
- R4: In the n-th write cycle after reset, addr_o = RD_BASE - (LAG - 1) + n, modulo 2^ADDR_W. With the defaults the first write address is 0x3FFF9.
- R5: The address of write cycle n + LAG - 1 equals the address of read cycle n. Equivalently, in every write cycle the read counter leads the write counter by exactly LAG (8 by default).
- R6: Both counters wrap modulo 2^ADDR_W. With the defaults, write address 0x3FFFF is followed by 0x00000. With ADDR_W = 6, read address 63 is followed by 0.
- R7: Pulling rst_n_i low in mid-run clears both strobes at once, without waiting for a clock edge. After release, the sequence starts again from R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| addr_o | output | ADDR_W | Shared memory address: the fetch location in read cycles, the store location in write cycles |
| rd_en_o | output | 1 | High in read cycles |
| wr_en_o | output | 1 | High in write cycles |

## Verification
A long run from reset walks both counters through at least forty slot pairs. It checks every read and every write address against a bench model, and it compares each store address with the fetch address recorded LAG-1 pairs earlier. That comparison separates a wrong starting offset from a wrong step. The same run takes the store counter across its top value into zero, which shows that it wraps rather than saturates. A second instance with a 6-bit bus is driven past the top of its fetch counter to show the same wrap on the other counter. A reset asserted in the middle of a store slot shows that the strobes drop at once and that both counters return to their start values, not to where they stopped.

// File: rtl/ilv_seq_pkg.sv
package ilv_seq_pkg;

  // Slot kind carried by the phase flip-flop.
  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WRITE = 1'b1
  } phase_e;

  function automatic phase_e flip_phase(input phase_e p);
    return (p == PH_READ) ? PH_WRITE : PH_READ;
  endfunction

endpackage

// File: rtl/ilv_rst_sync.sv
// Asynchronous assertion, synchronous release of the active-low reset.
module ilv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/ilv_phase_gen.sv
// Phase flip-flop: read slot after reset, toggles on every clock.
module ilv_phase_gen
  import ilv_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_n_i,
  output phase_e phase_o
);

  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    phase_d = flip_phase(phase_q);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) phase_q <= PH_READ;
    else          phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // R2: the slot kind changes on every clock once out of reset
  assert_phase_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    1'b1 |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/ilv_addr_ctr.sv
// Address counter with an explicit step enable; wraps modulo 2^W.
module ilv_addr_ctr #(
  parameter int           W     = 18,
  parameter logic [W-1:0] START = '0
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         step_en_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step_en_i) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= START;
    else          cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3 / R4 / R6: one step per enabled cycle, wrapping at the top
  assert_ctr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    step_en_i |=> (cnt_q == $past(cnt_q) + W'(1)));

  assert_ctr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !step_en_i |=> $stable(cnt_q));

endmodule

// File: rtl/ilv_addr_seq.sv
// Top: phase flip-flop, fetch and store counters, address selector.
module ilv_addr_seq
  import ilv_seq_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int LAG     = 8,
  parameter int RD_BASE = 0
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_en_o,
  output logic              wr_en_o
);

  localparam logic [ADDR_W-1:0] RD_START = ADDR_W'(RD_BASE);
  localparam logic [ADDR_W-1:0] WR_START = ADDR_W'(RD_BASE) - ADDR_W'(LAG - 1);

  logic              rst_sync_n;
  phase_e            phase;
  logic [ADDR_W-1:0] rd_cnt;
  logic [ADDR_W-1:0] wr_cnt;

  ilv_rst_sync #(.STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_sync_n)
  );

  ilv_phase_gen u_phase (
    .clk_i   (clk_i),
    .rst_n_i (rst_sync_n),
    .phase_o (phase)
  );

  // Strobes are held low until the synchronised reset has been released.
  always_comb begin
    rd_en_o = rst_sync_n && (phase == PH_READ);
    wr_en_o = rst_sync_n && (phase == PH_WRITE);
  end

  ilv_addr_ctr #(.W(ADDR_W), .START(RD_START)) u_rd_ctr (
    .clk_i     (clk_i),
    .rst_n_i   (rst_sync_n),
    .step_en_i (rd_en_o),
    .cnt_o     (rd_cnt)
  );

  ilv_addr_ctr #(.W(ADDR_W), .START(WR_START)) u_wr_ctr (
    .clk_i     (clk_i),
    .rst_n_i   (rst_sync_n),
    .step_en_i (wr_en_o),
    .cnt_o     (wr_cnt)
  );

  always_comb begin
    addr_o = (phase == PH_WRITE) ? wr_cnt : rd_cnt;
  end

  // R2: never both strobes
  assert_strobe_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !(rd_en_o && wr_en_o));

  // R5: in a store slot the fetch counter leads by exactly LAG
  assert_lag_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    wr_en_o |-> (ADDR_W'(rd_cnt - wr_cnt) == ADDR_W'(LAG)));

endmodule

// File: tb/ilv_addr_seq_test.sv
`timescale 1ns/1ps
module ilv_addr_seq_test;

  localparam int W = 18;
  localparam int MASK = (1 << W) - 1;
  localparam int WR0 = 'h3FFF9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] addr;
  logic         rd_en, wr_en;
  logic [5:0]   addr_s;
  logic         rd_s, wr_s;

  int n_checks = 0;
  int n_fail = 0;
  int hist [0:63];

  always #10 clk = ~clk;

  ilv_addr_seq uut (
    .clk_i(clk), .rst_n_i(rst_n), .addr_o(addr), .rd_en_o(rd_en), .wr_en_o(wr_en)
  );

  ilv_addr_seq #(.ADDR_W(6)) uut_small (
    .clk_i(clk), .rst_n_i(rst_n), .addr_o(addr_s), .rd_en_o(rd_s), .wr_en_o(wr_s)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Releases reset and leaves time at the negedge of the first read cycle.
  task automatic do_reset();
    bit found;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rd_en && !wr_en, "R1 strobes low in reset", {rd_en, wr_en}, 0);
    rst_n = 1'b1;
    found = 1'b0;
    for (int i = 0; i < 4 && !found; i++) begin
      @(negedge clk);
      if (rd_en || wr_en) found = 1'b1;
    end
    chk(found, "R1 first strobe within 3 cycles", found, 1);
    chk(rd_en && !wr_en, "R1 first slot is read", {rd_en, wr_en}, 2);
    chk(addr == 0, "R1 first read address", addr, 0);
  endtask

  task automatic t_sequence();
    do_reset();
    for (int n = 0; n < 40; n++) begin
      chk(rd_en && !wr_en, "R2 read slot strobes", {rd_en, wr_en}, 2);
      chk(addr == n, "R3 read address", addr, n);
      hist[n] = addr;
      @(negedge clk);
      chk(wr_en && !rd_en, "R2 write slot strobes", {rd_en, wr_en}, 1);
      chk(addr == ((WR0 + n) & MASK), "R4 write address", addr, (WR0 + n) & MASK);
      if (n >= 7) chk(addr == hist[n-7], "R5 write lands on source", addr, hist[n-7]);
      if (n == 6) chk(addr == 'h3FFFF, "R6 write top value", addr, 'h3FFFF);
      if (n == 7) chk(addr == 0, "R6 write wraps to zero", addr, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_wrap_small();
    do_reset();
    for (int n = 0; n < 70; n++) begin
      chk(rd_s && !wr_s, "R6 small read slot", {rd_s, wr_s}, 2);
      chk(addr_s == (n % 64), "R6 small read wraps", addr_s, n % 64);
      @(negedge clk);
      chk(addr_s == ((57 + n) % 64), "R6 small write address", addr_s, (57 + n) % 64);
      @(negedge clk);
    end
  endtask

  task automatic t_mid_reset();
    do_reset();
    repeat (9) @(negedge clk);
    chk(wr_en, "R7 in write slot before reset", wr_en, 1);
    #2 rst_n = 1'b0;
    #1 chk(!rd_en && !wr_en, "R7 strobes drop at once", {rd_en, wr_en}, 0);
    do_reset();
    chk(addr == 0, "R7 read restarts at base", addr, 0);
    @(negedge clk);
    chk(wr_en && addr == WR0, "R7 write restarts at start", addr, WR0);
  endtask

  initial begin
    t_sequence();
    t_wrap_small();
    t_mid_reset();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule